// File: doc/BRIEF.md
# Fixed-Point RGB to YCbCr Converter

This block converts one 8-bit unsigned RGB pixel per clock into a luma value and two offset chroma values. Every weight is an integer equal to the real weight times 1024. A term with a weight of exactly one half is not multiplied. It is built as a one-bit right shift of the input, placed on the same 1024 scale as 512 times the input.

The datapath has three register stages. The first stage forms the nine weighted terms. The second stage adds them with their signs, together with a rounding constant. The third stage drops the ten fraction bits, adds the chroma offset and limits the result to the 8-bit range. A valid flag travels with the data. A new pixel can enter on every cycle, and the output registers keep their last result while no sample arrives.

Top module: `ycc_conv`

## Requirements
- R1: For each accepted pixel, out_y = clamp(floor((306·R + 601·G + 116·B + 512) / 1024)) to 0..255.
- R2: out_cr = clamp(floor((512·R − 429·G − 83·B + 512) / 1024) + 128) to 0..255. The 512·R term is R shifted right by one bit and brought to the 1024 scale.
- R3: out_cb = clamp(floor((512·B − 173·R − 339·G + 512) / 1024) + 128) to 0..255. The 512·B term is built the same way as the half term in R2.
- R4: The sums are rounded to nearest by adding 512 before the ten fraction bits are dropped. For example, (R,G,B) = (0,0,5) gives Y=1, Cb=131 and Cr=128.
- R5: A chroma result above 255 is limited to 255, and a result below 0 is limited to 0. For example, pure red gives Cr=255 and pure blue gives Cb=255.
- R6: out_valid is high exactly when in_valid was high on the third rising edge before, counting the edge that sampled the pixel. The data for that pixel is present on the outputs at the same time.
- R7: While out_valid is low, out_y, out_cb and out_cr keep their last values, whatever is driven on in_r, in_g and in_b.
- R8: While rst is high on a rising edge, every register clears. After that edge out_valid, out_y, out_cb and out_cr are 0. Samples still in flight are dropped.
- R9: Any gray input (R = G = B) gives Cb = Cr = 128.
- R10: Pixels presented on consecutive cycles each produce their own result, on consecutive cycles and in input order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A pixel is present on in_r/in_g/in_b |
| in_r | input | DW | Red sample, unsigned |
| in_g | input | DW | Green sample, unsigned |
| in_b | input | DW | Blue sample, unsigned |
| out_valid | output | 1 | out_y/out_cb/out_cr hold a new result |
| out_y | output | DW | Luma |
| out_cb | output | DW | Blue-difference chroma, offset by 128 |
| out_cr | output | DW | Red-difference chroma, offset by 128 |

## Verification
A wrong weight, a wrong sign or a missing rounding constant shows up as a wrong value on one output. It appears exactly three edges after the pixel that exposes it. The stimulus therefore includes pixels where the rounding constant or the clamp changes the result, such as (0,0,5), pure red and pure blue. A valid flag that drifts away from its data, or a stage that loads without a valid sample, shows up in the same cycle. The result is either missing from the stream or comes out in the wrong place, or the output changes during idle cycles when it should hold. A stage that keeps its contents through reset shows up as a stray result in the cycles just after reset is released.

// File: rtl/ycc_pkg.sv
package ycc_pkg;

    localparam int FRAC  = 10;
    localparam int NCH   = 3;
    localparam int NTERM = 3;
    localparam int HALF  = 1 << (FRAC - 1);
    localparam int ROUND = 1 << (FRAC - 1);

    // channel index: 0 luma, 1 blue difference, 2 red difference
    // term index:    0 red,  1 green,           2 blue
    function automatic int coef(input int ch, input int t);
        case (ch * NTERM + t)
            0:       return 306;
            1:       return 601;
            2:       return 116;
            3:       return 173;
            4:       return 339;
            5:       return HALF;
            6:       return HALF;
            7:       return 429;
            default: return 83;
        endcase
    endfunction

    function automatic bit subtract(input int ch, input int t);
        if (ch == 1) return (t != 2);
        if (ch == 2) return (t != 0);
        return 1'b0;
    endfunction

    function automatic int offset(input int ch);
        return (ch == 0) ? 0 : 128;
    endfunction

endpackage

// File: rtl/ycc_mult_stage.sv
module ycc_mult_stage #(
    parameter int DW = 8,
    localparam int PW = DW + ycc_pkg::FRAC
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      in_valid,
    input  logic [2:0][DW-1:0]        in_pix,
    output logic                      out_valid,
    output logic [2:0][2:0][PW-1:0]   out_prod
);
    typedef struct packed {
        logic                    valid;
        logic [2:0][2:0][PW-1:0] prod;
    } mul_st_t;

    mul_st_t                 st_d, st_q;
    logic [2:0][2:0][PW-1:0] prod_c;

    for (genvar ch = 0; ch < ycc_pkg::NCH; ch++) begin : g_ch
        for (genvar t = 0; t < ycc_pkg::NTERM; t++) begin : g_term
            localparam int K = ycc_pkg::coef(ch, t);
            if (K == ycc_pkg::HALF) begin : g_half
                // half weight: shift right by one, realigned to the 2^FRAC scale
                assign prod_c[ch][t] = {1'b0, in_pix[t], {(ycc_pkg::FRAC - 1){1'b0}}};
            end else begin : g_mul
                assign prod_c[ch][t] = PW'(in_pix[t]) * PW'(K);
            end
        end
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) st_d.prod = prod_c;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign out_prod  = st_q.prod;
endmodule

// File: rtl/ycc_sum_stage.sv
module ycc_sum_stage #(
    parameter int DW = 8,
    localparam int PW = DW + ycc_pkg::FRAC,
    localparam int SW = PW + 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [2:0][2:0][PW-1:0] in_prod,
    output logic                    out_valid,
    output logic [2:0][SW-1:0]      out_sum
);
    typedef struct packed {
        logic                 valid;
        logic [2:0][SW-1:0]   sum;
    } sum_st_t;

    sum_st_t st_d, st_q;

    always_comb begin
        logic signed [SW-1:0] acc;
        st_d       = st_q;
        st_d.valid = in_valid;
        for (int ch = 0; ch < ycc_pkg::NCH; ch++) begin
            acc = SW'(ycc_pkg::ROUND);
            for (int t = 0; t < ycc_pkg::NTERM; t++) begin
                if (ycc_pkg::subtract(ch, t))
                    acc = acc - $signed({2'b00, in_prod[ch][t]});
                else
                    acc = acc + $signed({2'b00, in_prod[ch][t]});
            end
            if (in_valid) st_d.sum[ch] = acc;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign out_sum   = st_q.sum;
endmodule

// File: rtl/ycc_clamp_stage.sv
module ycc_clamp_stage #(
    parameter int DW = 8,
    localparam int PW = DW + ycc_pkg::FRAC,
    localparam int SW = PW + 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [2:0][SW-1:0] in_sum,
    output logic               out_valid,
    output logic [2:0][DW-1:0] out_pix
);
    localparam logic signed [SW-1:0] TOP = SW'((1 << DW) - 1);

    typedef struct packed {
        logic               valid;
        logic [2:0][DW-1:0] pix;
    } clp_st_t;

    clp_st_t st_d, st_q;

    always_comb begin
        logic signed [SW-1:0] q;
        st_d       = st_q;
        st_d.valid = in_valid;
        for (int ch = 0; ch < ycc_pkg::NCH; ch++) begin
            q = $signed(in_sum[ch]) >>> ycc_pkg::FRAC;
            q = q + SW'(ycc_pkg::offset(ch));
            if (in_valid) begin
                if (q < 0)        st_d.pix[ch] = '0;
                else if (q > TOP) st_d.pix[ch] = '1;
                else              st_d.pix[ch] = q[DW-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign out_pix   = st_q.pix;
endmodule

// File: rtl/ycc_conv.sv
module ycc_conv #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [DW-1:0] in_r,
    input  logic [DW-1:0] in_g,
    input  logic [DW-1:0] in_b,
    output logic          out_valid,
    output logic [DW-1:0] out_y,
    output logic [DW-1:0] out_cb,
    output logic [DW-1:0] out_cr
);
    localparam int PW = DW + ycc_pkg::FRAC;
    localparam int SW = PW + 2;

    logic [2:0][DW-1:0]        pix_in;
    logic                      mul_v, sum_v;
    logic [2:0][2:0][PW-1:0]   mul_p;
    logic [2:0][SW-1:0]        sum_s;
    logic [2:0][DW-1:0]        pix_out;

    assign pix_in = {in_b, in_g, in_r};

    ycc_mult_stage #(.DW(DW)) u_mul (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_pix(pix_in),
        .out_valid(mul_v), .out_prod(mul_p)
    );

    ycc_sum_stage #(.DW(DW)) u_sum (
        .clk(clk), .rst(rst),
        .in_valid(mul_v), .in_prod(mul_p),
        .out_valid(sum_v), .out_sum(sum_s)
    );

    ycc_clamp_stage #(.DW(DW)) u_clp (
        .clk(clk), .rst(rst),
        .in_valid(sum_v), .in_sum(sum_s),
        .out_valid(out_valid), .out_pix(pix_out)
    );

    assign out_y  = pix_out[0];
    assign out_cb = pix_out[1];
    assign out_cr = pix_out[2];
endmodule

// File: rtl/ycc_checker.sv
module ycc_checker #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic [DW-1:0] in_r,
    input logic [DW-1:0] in_g,
    input logic [DW-1:0] in_b,
    input logic          out_valid,
    input logic [DW-1:0] out_y,
    input logic [DW-1:0] out_cb,
    input logic [DW-1:0] out_cr
);
    logic [1:0] since_q;

    always_ff @(posedge clk) begin
        if (rst)                  since_q <= '0;
        else if (since_q != 2'd3) since_q <= since_q + 2'd1;
    end

    // R6: valid comes out three edges after it went in
    a_r6_valid_delay: assert property (@(posedge clk) disable iff (rst)
        (since_q == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    // R9: gray input gives neutral chroma
    a_r9_gray_neutral: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_r == in_g && in_g == in_b)
        |-> ##3 (out_cb == DW'(128) && out_cr == DW'(128)));

    // R4: black relies on rounding floor of 512/1024 to zero
    a_r4_black_round: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_r == '0 && in_g == '0 && in_b == '0)
        |-> ##3 (out_y == '0 && out_cb == DW'(128) && out_cr == DW'(128)));

    // R7: outputs hold while no result is delivered
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        (since_q >= 2'd2 && !out_valid)
        |-> ($stable(out_y) && $stable(out_cb) && $stable(out_cr)));

    // R8: reset leaves everything cleared
    a_r8_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && out_y == '0 && out_cb == '0 && out_cr == '0));
endmodule

bind ycc_conv ycc_checker #(.DW(DW)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .in_r(in_r), .in_g(in_g), .in_b(in_b),
    .out_valid(out_valid), .out_y(out_y), .out_cb(out_cb), .out_cr(out_cr)
);

// File: tb/tb_ycc_conv.sv
`timescale 1ns/1ps
module tb_ycc_conv;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_r = '0, in_g = '0, in_b = '0;
    logic       out_valid;
    logic [7:0] out_y, out_cb, out_cr;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;
    logic [2:0] vhist = '0;

    int    qy[$], qcb[$], qcr[$];
    string qtag[$];

    always #2.5 clk = ~clk;

    ycc_conv dut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .in_r(in_r), .in_g(in_g), .in_b(in_b),
        .out_valid(out_valid), .out_y(out_y), .out_cb(out_cb), .out_cr(out_cr)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int lim(input int v);
        return (v < 0) ? 0 : ((v > 255) ? 255 : v);
    endfunction

    function automatic void model(input int r, g, b, output int y, cb, cr);
        y  = lim((306*r + 601*g + 116*b + 512) >>> 10);
        cr = lim(((512*r - 429*g - 83*b + 512) >>> 10) + 128);
        cb = lim(((512*b - 173*r - 339*g + 512) >>> 10) + 128);
    endfunction

    always @(posedge clk) begin
        if (rst) vhist <= '0;
        else     vhist <= {vhist[1:0], in_valid};
    end

    // result monitor: R6 timing, R10 ordering, per-channel values R1/R2/R3
    always @(negedge clk) begin
        if (!rst) begin
            chk(out_valid == vhist[2], "R6", "out_valid", int'(out_valid), int'(vhist[2]));
            if (out_valid) begin
                if (qy.size() == 0) begin
                    chk(1'b0, "R10", "unexpected result", 1, 0);
                end else begin
                    string tg;
                    int ey, ecb, ecr;
                    ey = qy.pop_front(); ecb = qcb.pop_front();
                    ecr = qcr.pop_front(); tg = qtag.pop_front();
                    chk(int'(out_y) == ey,   {"R1 ", tg}, "Y",  int'(out_y),  ey);
                    chk(int'(out_cb) == ecb, {"R3 ", tg}, "Cb", int'(out_cb), ecb);
                    chk(int'(out_cr) == ecr, {"R2 ", tg}, "Cr", int'(out_cr), ecr);
                end
            end
        end
    end

    task automatic push(input int r, g, b, input int ey, ecb, ecr, input string tg);
        @(negedge clk);
        in_valid = 1'b1; in_r = 8'(r); in_g = 8'(g); in_b = 8'(b);
        qy.push_back(ey); qcb.push_back(ecb); qcr.push_back(ecr); qtag.push_back(tg);
    endtask

    task automatic send(input int r, g, b, input string tg);
        int y, cb, cr;
        model(r, g, b, y, cb, cr);
        push(r, g, b, y, cb, cr, tg);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_r = 8'($urandom); in_g = 8'($urandom); in_b = 8'($urandom);
        end
    endtask

    task automatic drain(input string tag);
        idle(5);
        chk(qy.size() == 0, tag, "results outstanding", qy.size(), 0);
    endtask

    // R8: reset state
    task automatic t_reset_state;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R8", "out_valid in reset", int'(out_valid), 0);
        chk(out_y == 8'd0 && out_cb == 8'd0 && out_cr == 8'd0, "R8", "outputs in reset",
            int'({out_y, out_cb, out_cr}), 0);
        rst = 1'b0;
        idle(3);
    endtask

    // corner colors; hand-worked values for black, white, red, blue (R5 clamp)
    task automatic t_corners;
        push(0, 0, 0, 0, 128, 128, "black");
        push(255, 255, 255, 255, 128, 128, "white");
        push(255, 0, 0, 76, 85, 255, "red R5");
        push(0, 0, 255, 29, 255, 107, "blue R5");
        send(0, 255, 0, "green R5");
        send(255, 255, 0, "yellow");
        send(0, 255, 255, "cyan");
        send(255, 0, 255, "magenta");
        drain("R10");
    endtask

    // R4: rounding changes every channel for (0,0,5)
    task automatic t_round;
        push(0, 0, 5, 1, 131, 128, "R4 round");
        send(1, 1, 2, "R4 round");
        send(3, 0, 0, "R4 round");
        drain("R4");
    endtask

    // R9: gray levels keep chroma at 128
    task automatic t_gray;
        int lv[6] = '{0, 1, 127, 128, 254, 255};
        foreach (lv[i]) begin
            int y, cb, cr;
            model(lv[i], lv[i], lv[i], y, cb, cr);
            push(lv[i], lv[i], lv[i], y, 128, 128, "R9 gray");
        end
        drain("R9");
    endtask

    // R10: back-to-back stream with occasional bubbles
    task automatic t_stream;
        for (int i = 0; i < 300; i++) begin
            send(int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
                 int'($urandom_range(0, 255)), "R10 stream");
            if ($urandom_range(0, 3) == 0) idle(1);
        end
        drain("R10");
    endtask

    // R7: outputs hold while inputs wiggle without valid
    task automatic t_hold;
        int y, cb, cr;
        model(10, 200, 30, y, cb, cr);
        push(10, 200, 30, y, cb, cr, "R7 hold");
        for (int i = 1; i <= 8; i++) begin
            idle(1);
            if (i >= 3) begin
                chk(int'(out_y) == y,   "R7", "held Y",  int'(out_y),  y);
                chk(int'(out_cb) == cb, "R7", "held Cb", int'(out_cb), cb);
                chk(int'(out_cr) == cr, "R7", "held Cr", int'(out_cr), cr);
            end
        end
    endtask

    // R8: reset drops samples in flight
    task automatic t_reset_flush;
        send(50, 60, 70, "R8 flush");
        send(80, 90, 100, "R8 flush");
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0;
        qy.delete(); qcb.delete(); qcr.delete(); qtag.delete();
        @(negedge clk);
        chk(out_valid == 1'b0, "R8", "out_valid after reset", int'(out_valid), 0);
        chk(out_y == 8'd0 && out_cb == 8'd0 && out_cr == 8'd0, "R8", "outputs after reset",
            int'({out_y, out_cb, out_cr}), 0);
        @(negedge clk);
        rst = 1'b0;
        drain("R8");
    endtask

    initial begin
        t_reset_state();
        t_corners();
        t_round();
        t_gray();
        t_stream();
        t_hold();
        t_reset_flush();
        done = 1'b1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end
endmodule